// File: doc/BRIEF.md
# Status Flags and Pin Output Driver

This block keeps four status flags and uses them, along with fixed levels and stored data patterns, to drive four general-purpose pins. Each flag has its own control byte. That byte picks one internal event that sets the flag and another that clears it. The events are the counter's decrement and increment rollovers, the synch pulse and four match pulses. The counter and the input conditioning are outside this block. Their results arrive as single-cycle pulses and as the live counter value.

Each pin has a control byte whose low three bits select a drive mode:

- input (output enable low);
- its status flag alone;
- its status flag chopped by a duty-cycle mask;
- a constant low or high;
- its bit of the data nibble stored in the fourth control byte;
- a four-step pattern, where the nibble in bits 7:4 of control bytes 0 to 3 is taken in turn and the step advances on every increment rollover.

The chop signal is formed from the low eight counter bits and an 8-bit mask. Selecting one counter bit gives a 50 % duty, and two adjacent bits give 25 %. A readback byte per pin returns the live state of all four pins in its upper nibble, next to that pin's control low nibble.

Top module: `pin_out_driver`

## Requirements
- R1: After reset all status flags are 0 and the pattern step is 0.
- R2: In each flag's control byte, bits 5:3 select the setting event. The codes are 0 none, 1 decrement rollover, 2 increment rollover, 3 synch, and 4 to 7 match pulse 0 to 3. The flag reads 1 in the cycle after that event.
- R3: Bits 2:0 of the same byte select the clearing event with the same codes. The flag reads 0 in the cycle after that event. With neither event present, the flag keeps its value.
- R4: When the setting and clearing events of a flag occur in the same cycle, the flag becomes 1.
- R5: The chop signal is the AND over bits 0 to 7 of (NOT mask OR counter). With mask 0x01 it is high for 128 of every 256 counts, and with mask 0x03 for 64.
- R6: Pin mode 3 drives the pin's status flag. Pin mode 2 drives the flag ANDed with the chop signal. Both modes assert the output enable.
- R7: Pin mode 6 drives 0 and pin mode 7 drives 1, both with the output enable asserted.
- R8: Pin mode 5 drives bit (4+pin) of control byte 3. Bits 7:4 of control bytes 0 to 2 have no effect in this mode.
- R9: Pin mode 4 drives bit (4+pin) of control byte k, where k is the pattern step. The step advances by one on each increment rollover, wraps from 3 to 0, and does not change on a decrement rollover.
- R10: Pin modes 0 and 1 deassert the output enable and drive 0, and the live pin state then follows the external pin input.
- R11: Readback byte k equals {live state of pins 3..0, bits 3:0 of control byte k}. A pin's live state is its driven value when enabled and its external input otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| count_val | input | CNT_W | Live counter value |
| match_pulse | input | 4 | Match event pulses 0..3 |
| roll_inc | input | 1 | Increment rollover pulse |
| roll_dec | input | 1 | Decrement rollover pulse |
| synch_pulse | input | 1 | Synch event pulse |
| stat_ctrl | input | 32 | Flag control bytes, byte k for flag k |
| pin_ctrl | input | 32 | Pin control bytes, byte k for pin k |
| chop_mask | input | TOG_W | Counter bit select for the chop signal |
| pin_in | input | 4 | External pin levels |
| pin_out | output | 4 | Pin drive values |
| pin_oe | output | 4 | Pin output enables |
| pin_rdbk | output | 32 | Readback bytes, byte k for pin k |

## Verification
The bench builds the block with its defaults: a 16-bit counter input and an 8-bit chop width. It sweeps all 64 pairs of set and clear codes, with a different pair on each flag. Each pair is driven by every single event and by all events together, so every code decode and the set-wins rule are exercised. With the 8-bit width, every counter value from 0 to 255 can be swept under several masks, and the duty counts can be compared with arithmetic. The pattern step is walked past its wrap point.

// File: rtl/pin_drv_pkg.sv
package pin_drv_pkg;

    localparam int NPIN = 4;

    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_RDEC = 3'd1,
        SRC_RINC = 3'd2,
        SRC_SYNC = 3'd3,
        SRC_M0   = 3'd4,
        SRC_M1   = 3'd5,
        SRC_M2   = 3'd6,
        SRC_M3   = 3'd7
    } evt_src_e;

    typedef enum logic [2:0] {
        PM_IN    = 3'd0,
        PM_RSV   = 3'd1,
        PM_CHOP  = 3'd2,
        PM_FLAG  = 3'd3,
        PM_SEQ   = 3'd4,
        PM_HOLD  = 3'd5,
        PM_LOW   = 3'd6,
        PM_HIGH  = 3'd7
    } pin_mode_e;

    function automatic logic evt_pick(input logic [2:0] code,
                                      input logic [NPIN-1:0] match,
                                      input logic rinc,
                                      input logic rdec,
                                      input logic sync);
        logic hit;
        case (evt_src_e'(code))
            SRC_RDEC: hit = rdec;
            SRC_RINC: hit = rinc;
            SRC_SYNC: hit = sync;
            SRC_M0:   hit = match[0];
            SRC_M1:   hit = match[1];
            SRC_M2:   hit = match[2];
            SRC_M3:   hit = match[3];
            default:  hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/status_bank.sv
module status_bank
    import pin_drv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPIN*8-1:0] stat_ctrl,
    input  logic [NPIN-1:0]   match_pulse,
    input  logic              roll_inc,
    input  logic              roll_dec,
    input  logic              synch_pulse,
    output logic [NPIN-1:0]   flag
);

    typedef struct packed {
        logic [NPIN-1:0] flag;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [NPIN-1:0] set_hit, clr_hit;

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NPIN; i++) begin
            set_hit[i] = evt_pick(stat_ctrl[i*8+3 +: 3], match_pulse,
                                  roll_inc, roll_dec, synch_pulse);
            clr_hit[i] = evt_pick(stat_ctrl[i*8 +: 3], match_pulse,
                                  roll_inc, roll_dec, synch_pulse);
            if (set_hit[i])
                bank_d.flag[i] = 1'b1;
            else if (clr_hit[i])
                bank_d.flag[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            bank_q <= '0;
        else
            bank_q <= bank_d;
    end

    assign flag = bank_q.flag;

    for (genvar g = 0; g < NPIN; g++) begin : g_chk
        // R4
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_hit[g] |=> flag[g]);
        // R3
        clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_hit[g] && !set_hit[g]) |=> !flag[g]);
        // R3
        hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_hit[g] && !set_hit[g]) |=> $stable(flag[g]));
    end

endmodule

// File: rtl/chop_gen.sv
module chop_gen #(
    parameter int CNT_W = 16,
    parameter int TOG_W = 8
) (
    input  logic [CNT_W-1:0] count_val,
    input  logic [TOG_W-1:0] chop_mask,
    output logic             chop
);

    logic [TOG_W-1:0] sel;

    always_comb begin
        sel  = ~chop_mask | count_val[TOG_W-1:0];
        chop = &sel;
    end

endmodule

// File: rtl/pattern_step.sv
module pattern_step #(
    parameter int STEPS = 4,
    localparam int IDX_W = (STEPS > 1) ? $clog2(STEPS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             roll_inc,
    output logic [IDX_W-1:0] idx
);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
    } step_t;

    step_t step_d, step_q;

    always_comb begin
        step_d = step_q;
        if (roll_inc) begin
            if (step_q.idx == IDX_W'(STEPS - 1))
                step_d.idx = '0;
            else
                step_d.idx = step_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            step_q <= '0;
        else
            step_q <= step_d;
    end

    assign idx = step_q.idx;

    // R9
    step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        roll_inc |=> (idx == (($past(idx) == IDX_W'(STEPS - 1)) ? '0 : $past(idx) + 1'b1)));
    // R9
    step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !roll_inc |=> $stable(idx));

endmodule

// File: rtl/pin_out_driver.sv
module pin_out_driver
    import pin_drv_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int TOG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  count_val,
    input  logic [NPIN-1:0]   match_pulse,
    input  logic              roll_inc,
    input  logic              roll_dec,
    input  logic              synch_pulse,
    input  logic [NPIN*8-1:0] stat_ctrl,
    input  logic [NPIN*8-1:0] pin_ctrl,
    input  logic [TOG_W-1:0]  chop_mask,
    input  logic [NPIN-1:0]   pin_in,
    output logic [NPIN-1:0]   pin_out,
    output logic [NPIN-1:0]   pin_oe,
    output logic [NPIN*8-1:0] pin_rdbk
);

    localparam int IDX_W = (NPIN > 1) ? $clog2(NPIN) : 1;
    localparam int LAST  = NPIN - 1;

    logic [NPIN-1:0]  flag;
    logic             chop;
    logic [IDX_W-1:0] seq_idx;
    logic [NPIN-1:0]  seq_nib, hold_nib, live;

    status_bank u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .stat_ctrl   (stat_ctrl),
        .match_pulse (match_pulse),
        .roll_inc    (roll_inc),
        .roll_dec    (roll_dec),
        .synch_pulse (synch_pulse),
        .flag        (flag)
    );

    chop_gen #(.CNT_W(CNT_W), .TOG_W(TOG_W)) u_chop (
        .count_val (count_val),
        .chop_mask (chop_mask),
        .chop      (chop)
    );

    pattern_step #(.STEPS(NPIN)) u_step (
        .clk      (clk),
        .rst_n    (rst_n),
        .roll_inc (roll_inc),
        .idx      (seq_idx)
    );

    always_comb begin
        seq_nib  = pin_ctrl[int'(seq_idx)*8 + 4 +: NPIN];
        hold_nib = pin_ctrl[LAST*8 + 4 +: NPIN];
    end

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        always_comb begin
            pin_oe[p]  = 1'b1;
            pin_out[p] = 1'b0;
            case (pin_mode_e'(pin_ctrl[p*8 +: 3]))
                PM_CHOP: pin_out[p] = flag[p] & chop;
                PM_FLAG: pin_out[p] = flag[p];
                PM_SEQ:  pin_out[p] = seq_nib[p];
                PM_HOLD: pin_out[p] = hold_nib[p];
                PM_LOW:  pin_out[p] = 1'b0;
                PM_HIGH: pin_out[p] = 1'b1;
                default: pin_oe[p]  = 1'b0;
            endcase
            live[p] = pin_oe[p] ? pin_out[p] : pin_in[p];
        end

        // R10
        idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !pin_oe[p] |-> (!pin_out[p] && (pin_rdbk[p*8+4+p] == pin_in[p])));
        // R6
        chop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pin_oe[p] && !flag[p] && pin_ctrl[p*8 +: 3] == 3'd2) |-> !pin_out[p]);
    end

    for (genvar k = 0; k < NPIN; k++) begin : g_rdbk
        assign pin_rdbk[k*8 +: 8] = {live, pin_ctrl[k*8 +: 4]};
    end

endmodule

// File: tb/pin_out_driver_test.sv
module pin_out_driver_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] count_val = '0;
    logic [3:0]  match_pulse = '0;
    logic        roll_inc = 1'b0, roll_dec = 1'b0, synch_pulse = 1'b0;
    logic [31:0] stat_ctrl = '0, pin_ctrl = '0;
    logic [7:0]  chop_mask = '0;
    logic [3:0]  pin_in = '0;
    logic [3:0]  pin_out, pin_oe;
    logic [31:0] pin_rdbk;

    int n_run = 0, n_fail = 0;
    logic [3:0] mflag = '0;
    int midx = 0;

    always #5 clk = ~clk;

    pin_out_driver uut (
        .clk(clk), .rst_n(rst_n), .count_val(count_val), .match_pulse(match_pulse),
        .roll_inc(roll_inc), .roll_dec(roll_dec), .synch_pulse(synch_pulse),
        .stat_ctrl(stat_ctrl), .pin_ctrl(pin_ctrl), .chop_mask(chop_mask),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_rdbk(pin_rdbk)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // event word bits: 0 dec rollover, 1 inc rollover, 2 synch, 3..6 match0..3
    function automatic bit ev_of(input int code, input logic [6:0] e);
        return (code == 0) ? 1'b0 : e[code-1];
    endfunction

    task automatic apply(input logic [6:0] e);
        roll_dec    = e[0];
        roll_inc    = e[1];
        synch_pulse = e[2];
        match_pulse = e[6:3];
        @(posedge clk);
        for (int c = 0; c < 4; c++) begin
            if (ev_of(int'(stat_ctrl[c*8+3 +: 3]), e))      mflag[c] = 1'b1;
            else if (ev_of(int'(stat_ctrl[c*8 +: 3]), e))   mflag[c] = 1'b0;
        end
        if (e[1]) midx = (midx + 1) % 4;
        @(negedge clk);
        roll_dec = 0; roll_inc = 0; synch_pulse = 0; match_pulse = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        mflag = '0; midx = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [6:0] evs [9];
        logic [3:0] nib [4];
        int ones;
        logic [7:0] masks [8];
        evs = '{7'h01, 7'h02, 7'h04, 7'h08, 7'h10, 7'h20, 7'h40, 7'h7F, 7'h00};
        masks = '{8'h01, 8'h03, 8'h07, 8'h0F, 8'h80, 8'hC0, 8'h00, 8'hFF};

        @(negedge clk);
        do_reset();
        // R1: flags zero, shown through flag mode on all pins
        pin_ctrl = {4{8'h03}};
        #1;
        chk(pin_out == 4'h0 && pin_oe == 4'hF, "R1 flags after reset", {pin_oe, pin_out}, 8'hF0);

        // R2 R3 R4: sweep all set/clear code pairs
        for (int s = 0; s < 8; s++) begin
            for (int r = 0; r < 8; r++) begin
                for (int c = 0; c < 4; c++) begin
                    stat_ctrl[c*8+3 +: 3] = 3'((s + c) % 8);
                    stat_ctrl[c*8 +: 3]   = 3'((r + 3*c) % 8);
                end
                for (int k = 0; k < 9; k++) begin
                    apply(evs[k]);
                    #1;
                    chk(pin_out == mflag && pin_oe == 4'hF, "R2/R3/R4 flag sweep", pin_out, mflag);
                end
            end
        end

        // R4 explicit: set and clear by the same synch event
        stat_ctrl = {4{8'b00_011_011}};
        apply(7'h04);
        #1;
        chk(pin_out == 4'hF, "R4 set beats clear", pin_out, 4'hF);

        // R5 R6: chop sweep with all flags high
        stat_ctrl = {4{8'b00_011_000}};
        apply(7'h04);
        pin_ctrl = {4{8'h02}};
        for (int m = 0; m < 8; m++) begin
            chop_mask = masks[m];
            ones = 0;
            for (int v = 0; v < 256; v++) begin
                logic exp_t;
                count_val = 16'(v) | 16'h5A00;
                exp_t = &(~masks[m] | 8'(v));
                #1;
                chk(pin_out == {4{exp_t}} && pin_oe == 4'hF, "R5/R6 chop output", pin_out, {4{exp_t}});
                if (pin_out[0]) ones++;
            end
            if (m == 0) chk(ones == 128, "R5 duty 1/2", ones, 128);
            if (m == 1) chk(ones == 64, "R5 duty 1/4", ones, 64);
        end
        // R6: flag low gates chop off; mode 3 follows flag
        stat_ctrl = {4{8'b00_000_011}};
        apply(7'h04);
        chop_mask = 8'h00;
        #1;
        chk(pin_out == 4'h0, "R6 chop with flag low", pin_out, 0);
        pin_ctrl = {4{8'h03}};
        #1;
        chk(pin_out == 4'h0 && pin_oe == 4'hF, "R6 flag mode low", pin_out, 0);

        // R7 fixed levels
        pin_ctrl = {4{8'hF6}};
        #1;
        chk(pin_out == 4'h0 && pin_oe == 4'hF, "R7 drive low", {pin_oe, pin_out}, 8'hF0);
        pin_ctrl = {4{8'h07}};
        #1;
        chk(pin_out == 4'hF && pin_oe == 4'hF, "R7 drive high", {pin_oe, pin_out}, 8'hFF);

        // R8 hold nibble from byte 3; other upper nibbles ignored
        for (int n = 0; n < 16; n++) begin
            pin_ctrl = {4'(n), 4'h5, {3{~4'(n), 4'h5}}};
            #1;
            chk(pin_out == 4'(n) && pin_oe == 4'hF, "R8 hold nibble", pin_out, n);
        end

        // R9 pattern sequence
        do_reset();
        nib = '{4'h3, 4'hA, 4'h6, 4'hC};
        pin_ctrl = {nib[3], 4'h4, nib[2], 4'h4, nib[1], 4'h4, nib[0], 4'h4};
        #1;
        chk(pin_out == nib[0], "R1/R9 step zero after reset", pin_out, nib[0]);
        for (int t = 0; t < 10; t++) begin
            apply(7'h01);
            #1;
            chk(pin_out == nib[midx], "R9 decrement rollover no step", pin_out, nib[midx]);
            apply(7'h02);
            #1;
            chk(pin_out == nib[midx], "R9 step advance and wrap", pin_out, nib[midx]);
        end

        // R10 input modes
        for (int n = 0; n < 16; n++) begin
            pin_in = 4'(n);
            pin_ctrl = {8'h01, 8'h00, 8'h01, 8'h00};
            #1;
            chk(pin_oe == 4'h0 && pin_out == 4'h0, "R10 input mode idle", {pin_oe, pin_out}, 0);
            chk(pin_rdbk[7:4] == 4'(n), "R10 live follows input", pin_rdbk[7:4], n);
        end

        // R11 readback mix: pin0 input, pin1 high, pin2 low, pin3 input
        for (int n = 0; n < 16; n++) begin
            logic [3:0] lv;
            pin_in = 4'(n);
            pin_ctrl = {8'h08, 8'h06, 8'h07, 8'h00};
            lv = {pin_in[3], 1'b0, 1'b1, pin_in[0]};
            #1;
            chk(pin_rdbk == {lv, 4'h8, lv, 4'h6, lv, 4'h7, lv, 4'h0}, "R11 readback bytes",
                pin_rdbk, {lv, 4'h8, lv, 4'h6, lv, 4'h7, lv, 4'h0});
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule